// File: doc/BRIEF.md
# SPI Master Shifter

This block is the transmit and receive engine of a byte-wide SPI master port. Writing a byte into it while it is idle starts a full-duplex transfer at once. Eight bits leave on `sdo` most significant bit first, while eight bits are gathered from `sdi`. The block drives `sck` itself. Three static controls select the following:

- the idle level of `sck`;
- whether the first clock edge of a bit falls at the start of the bit or in its middle;
- whether `sdi` is captured in the middle or at the end of the bit.

Every bit is made of two half-bit periods. The length of a half-bit comes from one of three sources:

- a fixed divider of the system clock;
- a divider set by an 8-bit reload value;
- an external timer tick.

When the eighth bit completes, the received byte moves into a read buffer and a sticky interrupt flag rises. A write that arrives during a transfer is refused and flagged. A byte that completes while the previous one is still unread is dropped and flagged. With the transmitter disabled the engine keeps receiving, which gives receive-only operation.

Top module: `spi_master_shifter`

## Requirements
- R1: A `buf_wr` pulse while `busy` is low starts a transfer in the next cycle. `busy` then stays high for exactly 16 half-bit periods and falls in the cycle the received byte reaches `buf_rdata`.
- R2: Bit 7-i of the written byte is driven on `sdo` during half-bit periods 2i and 2i+1 of the transfer (i = 0..7), so the most significant bit goes first.
- R3: The half-bit period is selected by `cfg_rate`:
  - code 0 gives 2 system clocks;
  - code 1 gives 8 system clocks;
  - code 2 gives 32 system clocks;
  - code 3 ends a half-bit on each cycle with `timer_tick` high;
  - code 4 gives 2*(`cfg_reload`+1) system clocks;
  - codes 5 to 7 behave as code 0.
- R4: While not busy, `sck` equals `cfg_idle_high`. During a transfer, `sck` is inverted from idle in the even half-bit periods when `cfg_launch_early` is 0, and in the odd half-bit periods when it is 1.
- R5: With `cfg_sample_late` at 0, each received bit is the `sdi` value in the last cycle of the first half of its bit. With `cfg_sample_late` at 1, it is the value in the last cycle of the second half.
- R6: At the end of a transfer `irq_flag` rises. It stays set until `status_clr`, and `buf_rdata` changes only at that moment.
- R7: A `buf_wr` while busy sets `wcol`. The written byte is ignored, so the ongoing transfer's `sdo` pattern and timing are unchanged.
- R8: A transfer that completes while the buffer has not been acknowledged by `buf_rd` since its last load sets `rx_ovf`. The new byte is discarded and `buf_rdata` keeps the old byte.
- R9: With `cfg_tx_en` at 0, `sdo` and `sdo_oe` are low, while reception and timing work as usual.
- R10: After reset the following hold: `busy`, `irq_flag`, `wcol` and `rx_ovf` are 0, `buf_rdata` is 0, and `sck` equals `cfg_idle_high`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_high | input | 1 | Idle level of sck |
| cfg_launch_early | input | 1 | 1: first sck edge in mid-bit; 0: at bit start |
| cfg_sample_late | input | 1 | 1: sample sdi at end of bit; 0: in mid-bit |
| cfg_tx_en | input | 1 | Enables the serial output |
| cfg_rate | input | 3 | Half-bit period source code |
| cfg_reload | input | 8 | Reload value of the programmable divider |
| timer_tick | input | 1 | External timer tick for rate code 3 |
| buf_wr | input | 1 | Write strobe of the data buffer |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Acknowledges that the received byte was read |
| status_clr | input | 1 | Clears irq_flag, wcol and rx_ovf |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable of sdo |
| buf_rdata | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| irq_flag | output | 1 | Sticky transfer-complete flag |
| wcol | output | 1 | Sticky write-collision flag |
| rx_ovf | output | 1 | Sticky receive-overflow flag |

## Verification
The hardest behaviour to observe from the ports is the choice of sample point, because a constant data line gives the same byte whichever point is used. The bench drives one byte on `sdi` during the first half of every bit and a different byte during the second half. Only the correct sample point then yields the expected result, and this is swept over all eight combinations of polarity, launch edge and sample point. The collision case is also hard to reach, so a second write is placed in the middle of a transfer. The overflow case is reached by running two transfers back to back without the read acknowledge.

// File: rtl/spi_shifter_pkg.sv
package spi_shifter_pkg;
    parameter int unsigned BYTE_W   = 8;
    parameter int unsigned RELOAD_W = 8;

    localparam int unsigned HALF_W = $clog2(2 * BYTE_W);
    localparam int unsigned DIV_W  = RELOAD_W + 2;

    typedef enum logic [2:0] {
        RATE_FAST   = 3'd0,
        RATE_MID    = 3'd1,
        RATE_SLOW   = 3'd2,
        RATE_TIMER  = 3'd3,
        RATE_RELOAD = 3'd4
    } rate_e;

    typedef struct packed {
        logic              busy;
        logic [HALF_W-1:0] half;
        logic [BYTE_W-1:0] sr;
        logic              samp;
        logic [BYTE_W-1:0] rxbuf;
        logic              full;
        logic              irq;
        logic              wcol;
        logic              ovf;
    } core_state_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_shifter_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [2:0]          rate_sel,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                timer_tick,
    output logic                half_tick
);
    logic [DIV_W-1:0] len;
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             use_timer;

    always_comb begin
        use_timer = 1'b0;
        case (rate_sel)
            RATE_MID:    len = DIV_W'(8);
            RATE_SLOW:   len = DIV_W'(32);
            RATE_TIMER:  begin len = DIV_W'(2); use_timer = 1'b1; end
            RATE_RELOAD: len = DIV_W'(2) * (DIV_W'(reload) + DIV_W'(1));
            default:     len = DIV_W'(2);
        endcase

        half_tick = run && (use_timer ? timer_tick : (cnt_q == '0));

        if (!run || cnt_q == '0) cnt_d = len - DIV_W'(1);
        else                     cnt_d = cnt_q - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_shifter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_high,
    input  logic              launch_early,
    input  logic              sample_late,
    input  logic              tx_en,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              status_clr,
    input  logic              sdi,
    input  logic              half_tick,
    output logic              busy,
    output logic              sck,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [BYTE_W-1:0] buf_rdata,
    output logic              irq,
    output logic              wcol,
    output logic              ovf
);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * BYTE_W - 1);

    core_state_t       d, q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        d       = q;
        shifted = {q.sr[BYTE_W-2:0], sample_late ? sdi : q.samp};

        if (status_clr) begin
            d.irq  = 1'b0;
            d.wcol = 1'b0;
            d.ovf  = 1'b0;
        end
        if (buf_rd) d.full = 1'b0;

        if (buf_wr && q.busy) d.wcol = 1'b1;
        if (buf_wr && !q.busy) begin
            d.busy = 1'b1;
            d.half = '0;
            d.sr   = buf_wdata;
        end

        if (q.busy && half_tick) begin
            if (!q.half[0]) d.samp = sdi;
            else            d.sr   = shifted;
            d.half = q.half + 1'b1;
            if (q.half == HALF_LAST) begin
                d.busy = 1'b0;
                d.irq  = 1'b1;
                if (q.full && !buf_rd) begin
                    d.ovf = 1'b1;
                end else begin
                    d.rxbuf = shifted;
                    d.full  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign sck       = idle_high ^ (q.busy & (q.half[0] ~^ launch_early));
    assign sdo       = tx_en & q.sr[BYTE_W-1];
    assign sdo_oe    = tx_en;
    assign buf_rdata = q.rxbuf;
    assign irq       = q.irq;
    assign wcol      = q.wcol;
    assign ovf       = q.ovf;
endmodule

// File: rtl/spi_master_shifter.sv
module spi_master_shifter
    import spi_shifter_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_idle_high,
    input  logic                cfg_launch_early,
    input  logic                cfg_sample_late,
    input  logic                cfg_tx_en,
    input  logic [2:0]          cfg_rate,
    input  logic [RELOAD_W-1:0] cfg_reload,
    input  logic                timer_tick,
    input  logic                buf_wr,
    input  logic [BYTE_W-1:0]   buf_wdata,
    input  logic                buf_rd,
    input  logic                status_clr,
    input  logic                sdi,
    output logic                sck,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [BYTE_W-1:0]   buf_rdata,
    output logic                busy,
    output logic                irq_flag,
    output logic                wcol,
    output logic                rx_ovf
);
    logic half_tick;

    spi_rate_gen u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy),
        .rate_sel   (cfg_rate),
        .reload     (cfg_reload),
        .timer_tick (timer_tick),
        .half_tick  (half_tick)
    );

    spi_shift_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_high    (cfg_idle_high),
        .launch_early (cfg_launch_early),
        .sample_late  (cfg_sample_late),
        .tx_en        (cfg_tx_en),
        .buf_wr       (buf_wr),
        .buf_wdata    (buf_wdata),
        .buf_rd       (buf_rd),
        .status_clr   (status_clr),
        .sdi          (sdi),
        .half_tick    (half_tick),
        .busy         (busy),
        .sck          (sck),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .buf_rdata    (buf_rdata),
        .irq          (irq_flag),
        .wcol         (wcol),
        .ovf          (rx_ovf)
    );
endmodule

// File: rtl/spi_shifter_checker.sv
module spi_shifter_checker
    import spi_shifter_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_idle_high,
    input logic              buf_wr,
    input logic              status_clr,
    input logic              sck,
    input logic [BYTE_W-1:0] buf_rdata,
    input logic              busy,
    input logic              irq_flag,
    input logic              wcol
);
    assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cfg_idle_high);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !status_clr |=> irq_flag);

    assert_buf_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(buf_rdata));

    assert_end_raises_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_flag);

    assert_collision_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && buf_wr && !status_clr |=> wcol);
endmodule

bind spi_master_shifter spi_shifter_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_idle_high (cfg_idle_high),
    .buf_wr        (buf_wr),
    .status_clr    (status_clr),
    .sck           (sck),
    .buf_rdata     (buf_rdata),
    .busy          (busy),
    .irq_flag      (irq_flag),
    .wcol          (wcol)
);

// File: tb/spi_master_shifter_bench.sv
`timescale 1ns/1ps
module spi_master_shifter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_idle_high = 1'b0, cfg_launch_early = 1'b0, cfg_sample_late = 1'b0, cfg_tx_en = 1'b1;
    logic [2:0] cfg_rate = 3'd0;
    logic [7:0] cfg_reload = 8'd0;
    logic       timer_tick = 1'b0, buf_wr = 1'b0, buf_rd = 1'b0, status_clr = 1'b0, sdi = 1'b0;
    logic [7:0] buf_wdata = 8'd0;
    logic       sck, sdo, sdo_oe, busy, irq_flag, wcol, rx_ovf;
    logic [7:0] buf_rdata;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_master_shifter u_spi_master_shifter (
        .clk(clk), .rst_n(rst_n), .cfg_idle_high(cfg_idle_high), .cfg_launch_early(cfg_launch_early),
        .cfg_sample_late(cfg_sample_late), .cfg_tx_en(cfg_tx_en), .cfg_rate(cfg_rate),
        .cfg_reload(cfg_reload), .timer_tick(timer_tick), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .status_clr(status_clr), .sdi(sdi), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe),
        .buf_rdata(buf_rdata), .busy(busy), .irq_flag(irq_flag), .wcol(wcol), .rx_ovf(rx_ovf)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One transfer; hl = half-bit length in cycles; sdi carries a in first halves, b in second halves.
    task automatic xfer(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b, input int hl,
                        input bit tmode, input bit collide, input logic [7:0] exp_buf,
                        input bit exp_ovf, input bit exp_wcol);
        int bad_busy = 0;
        int bad_sck = 0;
        int bad_sdo = 0;
        @(negedge clk);
        buf_wdata = tx;
        buf_wr = 1'b1;
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < hl; c++) begin
                @(negedge clk);
                buf_wr = collide && k == 5 && c == 0;
                if (buf_wr) buf_wdata = ~tx;
                sdi = (k % 2 == 0) ? a[7 - k/2] : b[7 - k/2];
                timer_tick = tmode && (c == hl - 1);
                if (busy !== 1'b1) bad_busy++;
                if (sck !== (cfg_idle_high ^ (((k % 2) == 1) == cfg_launch_early))) bad_sck++;
                if (sdo !== (cfg_tx_en & tx[7 - k/2])) bad_sdo++;
            end
        end
        @(negedge clk);
        timer_tick = 1'b0;
        sdi = 1'b0;
        check(bad_busy == 0 && busy == 1'b0, "R1", "busy window", bad_busy, 0);
        check(bad_busy == 0 && busy == 1'b0, "R3", "half-bit length", int'(busy), 0);
        check(bad_sck == 0 && sck == cfg_idle_high, "R4", "sck pattern", bad_sck, 0);
        check(bad_sdo == 0, "R2", "sdo pattern", bad_sdo, 0);
        check(buf_rdata == exp_buf, "R5", "received byte", buf_rdata, exp_buf);
        check(irq_flag == 1'b1, "R6", "irq after end", irq_flag, 1);
        check(rx_ovf == exp_ovf, "R8", "overflow flag", rx_ovf, exp_ovf);
        check(wcol == exp_wcol, "R7", "collision flag", wcol, exp_wcol);
        check(sdo_oe == cfg_tx_en, "R9", "sdo_oe", sdo_oe, cfg_tx_en);
    endtask

    task automatic tidy(input bit do_read);
        @(negedge clk);
        status_clr = 1'b1;
        buf_rd = do_read;
        @(negedge clk);
        status_clr = 1'b0;
        buf_rd = 1'b0;
        check(irq_flag == 1'b0 && wcol == 1'b0 && rx_ovf == 1'b0, "R6", "flags cleared",
              {irq_flag, wcol, rx_ovf}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] tx, a, b, first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && irq_flag == 0 && wcol == 0 && rx_ovf == 0, "R10", "reset flags",
              {busy, irq_flag, wcol, rx_ovf}, 0);
        check(buf_rdata == 8'h00 && sck == cfg_idle_high, "R10", "reset buffer/sck", buf_rdata, 0);

        // R4 R5 R2: sweep all polarity / launch / sample combinations
        for (int m = 0; m < 8; m++) begin
            cfg_idle_high = m[0];
            cfg_launch_early = m[1];
            cfg_sample_late = m[2];
            tx = 8'hA5 ^ 8'(m * 13);
            a = 8'h3C + 8'(m);
            b = ~a ^ 8'(m << 4);
            xfer(tx, a, b, 2, 1'b0, 1'b0, cfg_sample_late ? b : a, 1'b0, 1'b0);
            tidy(1'b1);
        end

        // R3: rate sources
        cfg_idle_high = 1'b0; cfg_launch_early = 1'b1; cfg_sample_late = 1'b0;
        cfg_rate = 3'd1; xfer(8'h96, 8'h5A, 8'hFF, 8, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0); tidy(1'b1);
        cfg_rate = 3'd2; xfer(8'h0F, 8'hC3, 8'h00, 32, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0); tidy(1'b1);
        cfg_rate = 3'd4; cfg_reload = 8'd0;
        xfer(8'h81, 8'h7E, 8'h11, 2, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0); tidy(1'b1);
        cfg_reload = 8'd3;
        xfer(8'h42, 8'h24, 8'hDB, 8, 1'b0, 1'b0, 8'h24, 1'b0, 1'b0); tidy(1'b1);
        cfg_rate = 3'd6;
        xfer(8'hE7, 8'h99, 8'h66, 2, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0); tidy(1'b1);
        cfg_rate = 3'd3; cfg_sample_late = 1'b1;
        xfer(8'h5C, 8'hAA, 8'h35, 3, 1'b1, 1'b0, 8'h35, 1'b0, 1'b0); tidy(1'b1);

        // R7: write collision mid-transfer
        cfg_rate = 3'd0; cfg_sample_late = 1'b0;
        xfer(8'hC6, 8'h1B, 8'h00, 2, 1'b0, 1'b1, 8'h1B, 1'b0, 1'b1); tidy(1'b1);

        // R8: second byte completes before the first is acknowledged
        first = 8'h6D;
        xfer(8'h12, first, first, 2, 1'b0, 1'b0, first, 1'b0, 1'b0); tidy(1'b0);
        xfer(8'h34, 8'hF0, 8'hF0, 2, 1'b0, 1'b0, first, 1'b1, 1'b0); tidy(1'b1);

        // R9: receive-only
        cfg_tx_en = 1'b0;
        xfer(8'hFF, 8'hB4, 8'h4B, 2, 1'b0, 1'b0, 8'hB4, 1'b0, 1'b0); tidy(1'b1);
        check(sdo == 1'b0, "R9", "sdo low when disabled", sdo, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule